// File: doc/BRIEF.md
# SD Host Command Issue Controller

This block issues a single command to an SD host controller and collects its outcome. A requester presents a 32-bit command code, a 32-bit argument, a block count and a flag that says whether the attached card is an SD card. The controller first checks that the command path is free. It then performs a fixed series of register writes: block count, data timeout, argument, and a clear of both interrupt status banks. Next it builds the 14-bit command word and writes it, which launches the command. After that it polls the interrupt summary lines until the command completes, an error is flagged, or a bounded number of polls runs out.

Bit 31 of the command code marks an application-specific command. It changes how the index is decoded but never reaches the command register. The response type and the data-present flag are chosen per index. For two indices they also depend on the card type. All register traffic leaves through one write strobe with a register select and a 32-bit data word, one write per cycle. The result is a one-cycle strobe with a pass or fail bit.

Top module: `sdcmd_issue`

## Requirements
- R1: A request (`req_valid` high) is taken only while `busy` is low. `busy` rises in the cycle after acceptance and stays high through the one-cycle `done` strobe, then falls. A `req_valid` seen while `busy` is high has no effect.
- R2: If `inhibit_cmd` is high in the acceptance cycle, the next cycle carries `done` with `pass` low, and no register write occurs.
- R3: Without inhibit, the five cycles after acceptance each carry one write, in this order:
  - select 0: the block count, zero-extended.
  - select 1: the value 0x0000000E.
  - select 2: the argument.
  - select 3: the value 0xFFFF.
  - select 4: the value 0xFFFF.
- R4: The command write uses select 5. Its data holds the request's bits 5:0 in bits 13:8 and the response flags in bits 7:0. Bits 31:14 are zero. Bit 31 and bits 30:6 of the request never appear in the word.
- R5: The response flag code depends on the command index:

  | Command | Code |
  |---|---|
  | Index 0 or 4 | 0x00 |
  | Index 1 or application 41 | 0x02 |
  | Index 2 or 9 | 0x09 |
  | Index 3 | 0x1A |
  | Index 5 | 0x1B |
  | 7, 10, 11, 12, 16, 55, application 13, any other index, any other application command | 0x1A |

- R6: Index 6 gives 0x3A for an SD card (`req_card_sd`=1) and 0x1B otherwise. Index 8 gives 0x1A for an SD card and 0x3A otherwise.
- R7: Indices 17, 18, 19 and 21, and application 51, give 0x3A, which is an R1 response with the data-present bit (flag bit 5) set.
- R8: If `inhibit_dat` is high in the cycle of the select-4 write and the framed word has its data-present bit set, the next cycle carries `done` with `pass` low and no command write. If the data-present bit is clear, `inhibit_dat` has no effect.
- R9: Each cycle after the command write is one poll. A poll that sees `irq_cmd_done` (without `irq_err_sum`) is followed by a select-3 write of 0x0001, then `done` with `pass` high.
- R10: A poll that sees `irq_err_sum` is followed by a select-4 write of 0xFFFF, then `done` with `pass` low. This holds even when `irq_cmd_done` is high in the same poll.
- R11: After `POLL_LIMIT` polls with neither line high, the next cycle carries `done` with `pass` low.
- R12: While reset is asserted and after it is released, `busy`, `wr_stb` and `done` are low, even if `req_valid` is high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 32 | Command code: bits 5:0 index, bit 31 application flag |
| req_arg | input | 32 | Command argument |
| req_blk_cnt | input | BLK_W | Block count |
| req_card_sd | input | 1 | 1 for an SD card, 0 for other cards |
| inhibit_cmd | input | 1 | Command path busy status |
| inhibit_dat | input | 1 | Data path busy status |
| irq_err_sum | input | 1 | Error summary status |
| irq_cmd_done | input | 1 | Command-complete status |
| busy | output | 1 | A request is in progress |
| wr_stb | output | 1 | Register write strobe |
| wr_sel | output | 3 | Register select (0 block count, 1 timeout, 2 argument, 3 normal status, 4 error status, 5 command) |
| wr_data | output | 32 | Register write data |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | Result, valid with `done` |

## Verification
The bench builds the block with `POLL_LIMIT` set to 12 and the default 16-bit block count. With that setting, the give-up path after a full run of silent polls takes a few cycles instead of millions, so it can be checked. Outcomes are placed on the first, a middle and late polls. An error and a completion in the same poll check the priority between them. Both card types are run through the two indices whose decode depends on them.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    // Sequencer states
    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_BLK  = 4'd1,
        ST_TMO  = 4'd2,
        ST_ARG  = 4'd3,
        ST_CLRN = 4'd4,
        ST_CLRE = 4'd5,
        ST_CMD  = 4'd6,
        ST_WAIT = 4'd7,
        ST_ACK  = 4'd8,
        ST_ERRC = 4'd9,
        ST_PASS = 4'd10,
        ST_FAIL = 4'd11
    } st_e;

    // Register select codes on the write port
    localparam logic [2:0] SEL_BLK  = 3'd0;
    localparam logic [2:0] SEL_TMO  = 3'd1;
    localparam logic [2:0] SEL_ARG  = 3'd2;
    localparam logic [2:0] SEL_NSTS = 3'd3;
    localparam logic [2:0] SEL_ESTS = 3'd4;
    localparam logic [2:0] SEL_CMD  = 3'd5;

    // Response flag codes (low byte of the command word)
    localparam logic [7:0] RSP_NONE = 8'h00;
    localparam logic [7:0] RSP_R1   = 8'h1A;
    localparam logic [7:0] RSP_R1B  = 8'h1B;
    localparam logic [7:0] RSP_R2   = 8'h09;
    localparam logic [7:0] RSP_R3   = 8'h02;
    localparam logic [7:0] RSP_R6   = 8'h1A;
    localparam logic [7:0] DAT_PRES = 8'h20;

    localparam int          CMD_WORD_W = 14;
    localparam logic [7:0]  TMO_CODE   = 8'h0E;
    localparam logic [15:0] STS_ALL    = 16'hFFFF;
    localparam logic [15:0] STS_CC     = 16'h0001;

endpackage

// File: rtl/sdcmd_frame.sv
module sdcmd_frame
    import sdcmd_pkg::*;
(
    input  logic [31:0]           cmd_code,
    input  logic                  card_sd,
    output logic [CMD_WORD_W-1:0] word,
    output logic                  data_present
);

    logic [5:0]  idx;
    logic        app;
    logic [7:0]  flags;
    logic [31:0] framed;
    logic        unused_hi;

    assign idx = cmd_code[5:0];
    assign app = cmd_code[31];

    always_comb begin
        flags = RSP_R1;
        if (app) begin
            case (idx)
                6'd41:   flags = RSP_R3;
                6'd13:   flags = RSP_R1;
                6'd51:   flags = RSP_R1 | DAT_PRES;
                default: flags = RSP_R1;
            endcase
        end else begin
            case (idx)
                6'd0, 6'd4:   flags = RSP_NONE;
                6'd1:         flags = RSP_R3;
                6'd2, 6'd9:   flags = RSP_R2;
                6'd3:         flags = RSP_R6;
                6'd5:         flags = RSP_R1B;
                6'd6:         flags = card_sd ? (RSP_R1 | DAT_PRES) : RSP_R1B;
                6'd8:         flags = card_sd ? RSP_R1 : (RSP_R1 | DAT_PRES);
                6'd17, 6'd18,
                6'd19, 6'd21: flags = RSP_R1 | DAT_PRES;
                6'd7, 6'd10, 6'd11, 6'd12,
                6'd16, 6'd55: flags = RSP_R1;
                default:      flags = RSP_R1;
            endcase
        end
    end

    // Index shifted into the upper byte, then masked to the register width
    assign framed       = {cmd_code[23:0], 8'h00} | {24'h0, flags};
    assign word         = framed[CMD_WORD_W-1:0];
    assign data_present = word[5];
    assign unused_hi    = ^framed[31:CMD_WORD_W];

endmodule

// File: rtl/sdcmd_poll_timer.sv
module sdcmd_poll_timer #(
    parameter int LIMIT = 32'h0080_0000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expired
);

    localparam int            CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + CW'(1);
        end
        expired = tick && (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sdcmd_issue.sv
module sdcmd_issue
    import sdcmd_pkg::*;
#(
    parameter int POLL_LIMIT = 32'h0080_0000,
    parameter int BLK_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_cmd,
    input  logic [31:0]      req_arg,
    input  logic [BLK_W-1:0] req_blk_cnt,
    input  logic             req_card_sd,
    input  logic             inhibit_cmd,
    input  logic             inhibit_dat,
    input  logic             irq_err_sum,
    input  logic             irq_cmd_done,
    output logic             busy,
    output logic             wr_stb,
    output logic [2:0]       wr_sel,
    output logic [31:0]      wr_data,
    output logic             done,
    output logic             pass
);

    localparam int ARG_W = 32;

    typedef struct packed {
        st_e                   st;
        logic [CMD_WORD_W-1:0] word;
        logic                  dp;
        logic [BLK_W-1:0]      blk;
        logic [ARG_W-1:0]      arg;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [CMD_WORD_W-1:0] frm_word;
    logic                  frm_dp;
    logic                  poll_tick, poll_clr, poll_expired;

    sdcmd_frame u_frame (
        .cmd_code     (req_cmd),
        .card_sd      (req_card_sd),
        .word         (frm_word),
        .data_present (frm_dp)
    );

    sdcmd_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (poll_clr),
        .tick    (poll_tick),
        .expired (poll_expired)
    );

    always_comb begin
        ctx_d     = ctx_q;
        poll_tick = 1'b0;
        poll_clr  = 1'b0;
        wr_stb    = 1'b0;
        wr_sel    = SEL_BLK;
        wr_data   = '0;
        done      = 1'b0;
        pass      = 1'b0;
        busy      = (ctx_q.st != ST_IDLE);

        case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.word = frm_word;
                    ctx_d.dp   = frm_dp;
                    ctx_d.blk  = req_blk_cnt;
                    ctx_d.arg  = req_arg;
                    ctx_d.st   = inhibit_cmd ? ST_FAIL : ST_BLK;
                end
            end
            ST_BLK: begin
                wr_stb   = 1'b1;
                wr_sel   = SEL_BLK;
                wr_data  = 32'(ctx_q.blk);
                ctx_d.st = ST_TMO;
            end
            ST_TMO: begin
                wr_stb   = 1'b1;
                wr_sel   = SEL_TMO;
                wr_data  = {24'h0, TMO_CODE};
                ctx_d.st = ST_ARG;
            end
            ST_ARG: begin
                wr_stb   = 1'b1;
                wr_sel   = SEL_ARG;
                wr_data  = ctx_q.arg;
                ctx_d.st = ST_CLRN;
            end
            ST_CLRN: begin
                wr_stb   = 1'b1;
                wr_sel   = SEL_NSTS;
                wr_data  = {16'h0, STS_ALL};
                ctx_d.st = ST_CLRE;
            end
            ST_CLRE: begin
                wr_stb   = 1'b1;
                wr_sel   = SEL_ESTS;
                wr_data  = {16'h0, STS_ALL};
                ctx_d.st = (inhibit_dat && ctx_q.dp) ? ST_FAIL : ST_CMD;
            end
            ST_CMD: begin
                wr_stb   = 1'b1;
                wr_sel   = SEL_CMD;
                wr_data  = {{(32-CMD_WORD_W){1'b0}}, ctx_q.word};
                poll_clr = 1'b1;
                ctx_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (irq_err_sum) begin
                    ctx_d.st = ST_ERRC;
                end else if (irq_cmd_done) begin
                    ctx_d.st = ST_ACK;
                end else begin
                    poll_tick = 1'b1;
                    if (poll_expired) begin
                        ctx_d.st = ST_FAIL;
                    end
                end
            end
            ST_ACK: begin
                wr_stb   = 1'b1;
                wr_sel   = SEL_NSTS;
                wr_data  = {16'h0, STS_CC};
                ctx_d.st = ST_PASS;
            end
            ST_ERRC: begin
                wr_stb   = 1'b1;
                wr_sel   = SEL_ESTS;
                wr_data  = {16'h0, STS_ALL};
                ctx_d.st = ST_FAIL;
            end
            ST_PASS: begin
                done     = 1'b1;
                pass     = 1'b1;
                ctx_d.st = ST_IDLE;
            end
            ST_FAIL: begin
                done     = 1'b1;
                ctx_d.st = ST_IDLE;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

endmodule

// File: rtl/sdcmd_issue_chk.sv
module sdcmd_issue_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        inhibit_cmd,
    input logic        inhibit_dat,
    input logic        busy,
    input logic        wr_stb,
    input logic [2:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic        done,
    input logic        pass
);

    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_stb_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> busy);

    assert_inhibit_fail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && inhibit_cmd) |=> (done && !pass && !wr_stb));

    assert_tmo_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel == 3'd1) |-> $past(wr_stb && wr_sel == 3'd0));

    assert_cmd_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel == 3'd5) |-> $past(wr_stb && wr_sel == 3'd4));

    assert_cmd_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel == 3'd5) |-> (wr_data[31:14] == 18'h0));

    assert_dat_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel == 3'd5 && wr_data[5]) |-> !$past(inhibit_dat));

    assert_pass_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> $past(wr_stb && wr_sel == 3'd3 && wr_data == 32'h1));

endmodule

bind sdcmd_issue sdcmd_issue_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .inhibit_cmd (inhibit_cmd),
    .inhibit_dat (inhibit_dat),
    .busy        (busy),
    .wr_stb      (wr_stb),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .done        (done),
    .pass        (pass)
);

// File: tb/sdcmd_issue_tb_top.sv
module sdcmd_issue_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 12;

    typedef struct packed {
        logic        busy;
        logic        stb;
        logic [2:0]  sel;
        logic [31:0] data;
        logic        done;
        logic        pass;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_cmd;
    logic [31:0] req_arg;
    logic [15:0] req_blk_cnt;
    logic        req_card_sd;
    logic        inhibit_cmd;
    logic        inhibit_dat;
    logic        irq_err_sum;
    logic        irq_cmd_done;
    logic        busy;
    logic        wr_stb;
    logic [2:0]  wr_sel;
    logic [31:0] wr_data;
    logic        done;
    logic        pass;

    int checks = 0;
    int errors = 0;

    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdcmd_issue #(.POLL_LIMIT(LIMIT), .BLK_W(16)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_cmd      (req_cmd),
        .req_arg      (req_arg),
        .req_blk_cnt  (req_blk_cnt),
        .req_card_sd  (req_card_sd),
        .inhibit_cmd  (inhibit_cmd),
        .inhibit_dat  (inhibit_dat),
        .irq_err_sum  (irq_err_sum),
        .irq_cmd_done (irq_cmd_done),
        .busy         (busy),
        .wr_stb       (wr_stb),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .done         (done),
        .pass         (pass)
    );

    // Expected command word from the requirement tables (R4-R7)
    function automatic logic [13:0] exp_word(input logic [31:0] c, input bit sd);
        int         n;
        bit         a;
        logic [7:0] f;
        n = int'(c[5:0]);
        a = c[31];
        if (a && n == 41)                            f = 8'h02;
        else if (a && n == 51)                       f = 8'h3A;
        else if (a)                                  f = 8'h1A;
        else if (n == 0 || n == 4)                   f = 8'h00;
        else if (n == 1)                             f = 8'h02;
        else if (n == 2 || n == 9)                   f = 8'h09;
        else if (n == 5)                             f = 8'h1B;
        else if (n == 6)                             f = sd ? 8'h3A : 8'h1B;
        else if (n == 8)                             f = sd ? 8'h1A : 8'h3A;
        else if (n == 17 || n == 18 || n == 19 || n == 21) f = 8'h3A;
        else                                         f = 8'h1A;
        return {c[5:0], f};
    endfunction

    task automatic push(input logic b, input logic s, input logic [2:0] sl,
                        input logic [31:0] d, input logic dn, input logic p,
                        input string t);
        exp_t e;
        e = '{busy: b, stb: s, sel: sl, data: d, done: dn, pass: p};
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic check_now();
        exp_t  e;
        string t;
        bit    bad;
        if (exp_q.size() == 0) begin
            e = '0;
            t = "R1";
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end
        checks++;
        bad = (busy !== e.busy) || (wr_stb !== e.stb) || (done !== e.done) ||
              (e.stb && ((wr_sel !== e.sel) || (wr_data !== e.data))) ||
              (e.done && (pass !== e.pass));
        if (bad) begin
            errors++;
            $display("FAIL %s: actual busy=%0b stb=%0b sel=%0d data=%h done=%0b pass=%0b expected busy=%0b stb=%0b sel=%0d data=%h done=%0b pass=%0b",
                     t, busy, wr_stb, wr_sel, wr_data, done, pass,
                     e.busy, e.stb, e.sel, e.data, e.done, e.pass);
        end
    endtask

    // outcome: 0 silent (timeout), 1 completion, 2 error, 3 both at once
    task automatic run_req(input logic [31:0] cmd, input logic [31:0] arg,
                           input logic [15:0] blk, input bit sd, input bit ic,
                           input bit idt, input int outcome, input int poll,
                           input string tag, input bit intrude);
        logic [13:0] w;
        w = exp_word(cmd, sd);
        if (ic) begin
            push(1, 0, 0, 0, 1, 0, "R2");
        end else begin
            push(1, 1, 3'd0, {16'h0, blk}, 0, 0, "R3");
            push(1, 1, 3'd1, 32'hE, 0, 0, "R3");
            push(1, 1, 3'd2, arg, 0, 0, "R3");
            push(1, 1, 3'd3, 32'hFFFF, 0, 0, "R3");
            push(1, 1, 3'd4, 32'hFFFF, 0, 0, "R3");
            if (idt && w[5]) begin
                push(1, 0, 0, 0, 1, 0, "R8");
            end else begin
                push(1, 1, 3'd5, {18'h0, w}, 0, 0, tag);
                if (outcome == 0) begin
                    for (int i = 0; i < LIMIT; i++) push(1, 0, 0, 0, 0, 0, "R11");
                    push(1, 0, 0, 0, 1, 0, "R11");
                end else begin
                    for (int i = 0; i <= poll; i++) push(1, 0, 0, 0, 0, 0, "R9");
                    if (outcome == 1) begin
                        push(1, 1, 3'd3, 32'h1, 0, 0, "R9");
                        push(1, 0, 0, 0, 1, 1, "R9");
                    end else begin
                        push(1, 1, 3'd4, 32'hFFFF, 0, 0, "R10");
                        push(1, 0, 0, 0, 1, 0, "R10");
                    end
                end
            end
        end

        req_valid   = 1'b1;
        req_cmd     = cmd;
        req_arg     = arg;
        req_blk_cnt = blk;
        req_card_sd = sd;
        inhibit_cmd = ic;
        inhibit_dat = idt;
        @(posedge clk);
        @(negedge clk);
        for (int c = 1; exp_q.size() > 0; c++) begin
            check_now();
            req_valid   = (intrude && c == 3);
            if (intrude && c == 3) begin
                req_cmd = 32'd17;
                req_arg = 32'hDEAD_BEEF;
            end
            inhibit_cmd  = 1'b0;
            irq_err_sum  = (outcome >= 2) && (c == 7 + poll);
            irq_cmd_done = (outcome == 1 || outcome == 3) && (c == 7 + poll);
            @(posedge clk);
            @(negedge clk);
        end
        req_valid    = 1'b0;
        inhibit_dat  = 1'b0;
        irq_err_sum  = 1'b0;
        irq_cmd_done = 1'b0;
        check_now(); // R1: back to idle, nothing further issued
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n        = 1'b0;
        req_valid    = 1'b1;
        req_cmd      = 32'd17;
        req_arg      = '0;
        req_blk_cnt  = '0;
        req_card_sd  = 1'b1;
        inhibit_cmd  = 1'b0;
        inhibit_dat  = 1'b0;
        irq_err_sum  = 1'b0;
        irq_cmd_done = 1'b0;
        repeat (3) @(negedge clk);
        exp_q.push_back('0); tag_q.push_back("R12");
        check_now();
        req_valid = 1'b0;
        rst_n     = 1'b1;
        @(negedge clk);
        exp_q.push_back('0); tag_q.push_back("R12");
        check_now();

        // R5 response codes
        run_req(32'd0,  32'h0,        16'd0,   1, 0, 0, 1, 0, "R5", 0);
        run_req(32'd2,  32'h1234_5678, 16'd1,  1, 0, 0, 1, 3, "R5", 0);
        run_req(32'd1,  32'h40FF_8000, 16'd0,  0, 0, 0, 1, 1, "R5", 0);
        run_req(32'd3,  32'h0,        16'd0,   1, 0, 0, 1, 0, "R5", 0);
        run_req(32'd5,  32'h0,        16'd0,   0, 0, 0, 1, 2, "R5", 0);
        run_req(32'd55, 32'hABCD_0000, 16'd0,  1, 0, 0, 1, 0, "R5", 0);
        run_req(32'd9,  32'hABCD_0000, 16'd0,  1, 0, 0, 1, 0, "R5", 0);
        // R4 application flag and stray upper bits
        run_req(32'h8000_0029, 32'h4030_0000, 16'd0, 1, 0, 0, 1, 0, "R4", 0);
        run_req(32'd41, 32'h0,        16'd0,   1, 0, 0, 1, 0, "R4", 0);
        run_req(32'h7FFF_FFC2, 32'h0, 16'd0,   1, 0, 0, 1, 0, "R4", 0);
        // R6 card-type dependence
        run_req(32'd6,  32'h00FF_FFF1, 16'd1,  1, 0, 0, 1, 0, "R6", 0);
        run_req(32'd6,  32'h03B7_0100, 16'd0,  0, 0, 0, 1, 0, "R6", 0);
        run_req(32'd8,  32'h0000_01AA, 16'd0,  1, 0, 0, 1, 0, "R6", 0);
        run_req(32'd8,  32'h0,        16'd1,   0, 0, 0, 1, 0, "R6", 0);
        // R7 data-present commands
        run_req(32'd17, 32'h0000_0200, 16'd1,  1, 0, 0, 1, 5, "R7", 0);
        run_req(32'd18, 32'h0000_0400, 16'hFFFF, 1, 0, 0, 1, 0, "R7", 0);
        run_req(32'h8000_0033, 32'h0, 16'd1,   1, 0, 0, 1, 0, "R7", 0);
        // R2 command inhibit
        run_req(32'd17, 32'h0,        16'd1,   1, 1, 0, 1, 0, "R2", 0);
        // R8 data inhibit: blocks data command, ignored otherwise
        run_req(32'd17, 32'h0,        16'd1,   1, 0, 1, 1, 0, "R8", 0);
        run_req(32'd7,  32'h1111_0000, 16'd0,  1, 0, 1, 1, 0, "R8", 0);
        // R10 error, alone and together with completion
        run_req(32'd2,  32'h0,        16'd0,   1, 0, 0, 2, 2, "R10", 0);
        run_req(32'd3,  32'h0,        16'd0,   1, 0, 0, 3, 0, "R10", 0);
        // R11 timeout; outcome on the last allowed poll still counts
        run_req(32'd16, 32'h200,      16'd0,   1, 0, 0, 0, 0, "R11", 0);
        run_req(32'd16, 32'h200,      16'd0,   1, 0, 0, 1, LIMIT - 1, "R11", 0);
        // R1 request while busy is ignored
        run_req(32'd7,  32'h5555_0000, 16'd3,  1, 0, 0, 1, 1, "R1", 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule